// File: doc/BRIEF.md
# Delay-Slot Exception Entry Controller

This block starts exception handling for a pipeline that has branch delay slots. The pipeline sends a request as a pulse that lasts one cycle. The request carries a 5-bit cause code and class flags: TLB refill, interrupt, and coprocessor number. With the request come the current PC, the next PC, the faulting address, the exception base address and the status control bits (boot-vector select, vectored-interrupt enable, exception shadow set). The block then updates its status, cause, exception-PC, bad-address and shadow-set registers. On the following cycle it redirects fetch to the chosen handler and supplies the next two sequential fetch addresses.

The block picks the handler offset from the state it holds before the update. A TLB refill taken while the exception-level flag is clear goes to the base address itself. Refills taken while the flag is set, and ordinary exceptions, go to base + 0x180. A vectored interrupt goes to base + 0x200. An overflow taken while the boot-vector bit is set goes to a fixed boot address. A combinational read port lets any internal register be examined.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When `cur_pc + 4 != nxt_pc` on a request, the block records EPC as `cur_pc - 4` and sets the delay-slot flag (cause bit 7). Otherwise it records EPC as `cur_pc` and clears that flag.
- R2: Every request writes `exc_code` into cause bits [4:0] and sets the exception-level flag (status bit 0), even if the flag is already set. Cause bits [6:5] are cleared unless R10 applies.
- R3: An ordinary request goes to handler `ebase + 0x180`. Exception: an overflow (code 0x0C) taken while `bev` is 1 goes to 0xBFC00200.
- R4: For a refill request (`exc_refill`=1), the exception-level flag is sampled before it is set. If the flag was 0 the handler is `ebase`; if it was 1 the handler is `ebase + 0x180`. Refill takes priority over the interrupt flag and over the overflow rule.
- R5: For an interrupt request (`exc_intr`=1, no refill), the handler is `ebase + 0x200` when `iv` is 1, and `ebase + 0x180` when `iv` is 0.
- R6: The shadow-set register updates only when the exception-level flag and `bev` are both 0 on entry. The old current set (bits [3:0]) moves into the previous set (bits [7:4]), and `ess` becomes the current set. In all other cases both fields hold.
- R7: In the cycle after a request, `redirect` is 1 for one cycle. At the same time `fetch_pc`, `fetch_npc` and `fetch_nnpc` show the handler, handler + 4 and handler + 8.
- R8: While `rst_n` is low, every register reads 0, `redirect` is 0 and fetch shows 0xBFC00000, 0xBFC00004 and 0xBFC00008. A request that arrives during reset has no effect.
- R9: Codes 0x1 to 0x5, and any refill request, latch `bad_addr` into the bad-address register. Any other request leaves that register unchanged.
- R10: For a coprocessor-unusable request (code 0x0B), cause bits [6:5] receive `cp_num`.
- R11: The read port is combinational, and unused bits read as 0. `rd_sel` values: 0 = status (bit 0 is the exception-level flag), 1 = cause, 2 = EPC, 3 = bad address, 4 = shadow set. Any other value reads 0.
- R12: In a cycle with no request, every register and every fetch output holds its value, and `redirect` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | One-cycle exception request |
| exc_code | input | 5 | Cause code |
| exc_refill | input | 1 | Request is a TLB refill |
| exc_intr | input | 1 | Request is an interrupt |
| cp_num | input | 2 | Coprocessor number for code 0x0B |
| cur_pc | input | 32 | PC of the faulting instruction |
| nxt_pc | input | 32 | Next PC in the pipeline |
| bad_addr | input | 32 | Faulting data/fetch address |
| ebase | input | 32 | Exception base address |
| bev | input | 1 | Boot-vector select |
| iv | input | 1 | Vectored-interrupt enable |
| ess | input | 4 | Shadow set for exceptions |
| redirect | output | 1 | Fetch redirect strobe |
| fetch_pc | output | 32 | Handler address |
| fetch_npc | output | 32 | Handler + 4 |
| fetch_nnpc | output | 32 | Handler + 8 |
| rd_sel | input | 3 | Read-port register select |
| rd_data | output | 32 | Read-port data |

## Verification
If the exception-level flag is wrong, the next refill goes to the wrong handler, and the flag also shows in status bit 0 one cycle after the request. A missed delay-slot detection shows up in the EPC value and the cause flag one cycle after the request, not when the handler later returns. The bench compares every register through the read port on every cycle. A stale or misrouted field is therefore caught in the cycle after the faulty update, before a later request can hide it.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN   = 32;
  localparam int CODE_W = 5;
  localparam int CP_W   = 2;
  localparam int SS_W   = 4;

  localparam logic [31:0] BOOT_RESET = 32'hBFC0_0000;
  localparam logic [31:0] BOOT_OVF   = 32'hBFC0_0200;
  localparam logic [31:0] OFF_REFILL = 32'h0000_0000;
  localparam logic [31:0] OFF_GEN    = 32'h0000_0180;
  localparam logic [31:0] OFF_VINT   = 32'h0000_0200;
  localparam logic [31:0] INSN_BYTES = 32'd4;

  typedef enum logic [4:0] {
    C_INT    = 5'h00,
    C_TLBMOD = 5'h01,
    C_TLBLD  = 5'h02,
    C_TLBST  = 5'h03,
    C_ADEL   = 5'h04,
    C_ADES   = 5'h05,
    C_SYS    = 5'h08,
    C_BRK    = 5'h09,
    C_RSVD   = 5'h0A,
    C_CPU    = 5'h0B,
    C_OVF    = 5'h0C,
    C_TRAP   = 5'h0D
  } cause_e;

  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_CAUSE  = 3'd1,
    SEL_EPC    = 3'd2,
    SEL_BAD    = 3'd3,
    SEL_SHADOW = 3'd4
  } rd_sel_e;
endpackage

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
  import exc_entry_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 5
) (
  input  logic          refill_i,
  input  logic          intr_i,
  input  logic [CW-1:0] code_i,
  input  logic          exl_i,
  input  logic          bev_i,
  input  logic          iv_i,
  input  logic [AW-1:0] base_i,
  output logic [AW-1:0] handler_o
);
  localparam logic [AW-1:0] GEN_OFS  = AW'(OFF_GEN);
  localparam logic [AW-1:0] REF_OFS  = AW'(OFF_REFILL);
  localparam logic [AW-1:0] VINT_OFS = AW'(OFF_VINT);
  localparam logic [AW-1:0] OVF_BOOT = AW'(BOOT_OVF);
  localparam logic [CW-1:0] OVF_CODE = CW'(C_OVF);

  always_comb begin
    if (refill_i) begin
      handler_o = exl_i ? (base_i + GEN_OFS) : (base_i + REF_OFS);
    end else if (intr_i) begin
      handler_o = iv_i ? (base_i + VINT_OFS) : (base_i + GEN_OFS);
    end else if ((code_i == OVF_CODE) && bev_i) begin
      handler_o = OVF_BOOT;
    end else begin
      handler_o = base_i + GEN_OFS;
    end
  end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_entry_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 5,
  parameter int PW   = 2,
  parameter int SW   = 4
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [CW-1:0] code_i,
  input  logic          refill_i,
  input  logic [PW-1:0] cp_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] npc_i,
  input  logic [AW-1:0] bad_i,
  input  logic          bev_i,
  input  logic [SW-1:0] ess_i,
  output logic          exl_o,
  output logic [CW-1:0] code_o,
  output logic [PW-1:0] ce_o,
  output logic          bd_o,
  output logic [AW-1:0] epc_o,
  output logic [AW-1:0] bad_o,
  output logic [SW-1:0] css_o,
  output logic [SW-1:0] pss_o
);
  localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

  logic          exl_q, exl_d;
  logic [CW-1:0] code_q, code_d;
  logic [PW-1:0] ce_q, ce_d;
  logic          bd_q, bd_d;
  logic [AW-1:0] epc_q, epc_d;
  logic [AW-1:0] bad_q, bad_d;
  logic [SW-1:0] css_q, css_d, pss_q, pss_d;
  logic          slot, grab_bad, shadow_en;

  assign slot      = (pc_i + STEP) != npc_i;
  assign grab_bad  = refill_i || ((code_i >= CW'(C_TLBMOD)) && (code_i <= CW'(C_ADES)));
  assign shadow_en = req_i && !exl_q && !bev_i;

  always_comb begin
    exl_d  = exl_q;
    code_d = code_q;
    ce_d   = ce_q;
    bd_d   = bd_q;
    epc_d  = epc_q;
    bad_d  = bad_q;
    css_d  = css_q;
    pss_d  = pss_q;
    if (req_i) begin
      exl_d  = 1'b1;
      code_d = code_i;
      ce_d   = (code_i == CW'(C_CPU)) ? cp_i : '0;
      bd_d   = slot;
      epc_d  = slot ? (pc_i - STEP) : pc_i;
      if (grab_bad) bad_d = bad_i;
    end
    if (shadow_en) begin
      pss_d = css_q;
      css_d = ess_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      exl_q  <= 1'b0;
      code_q <= '0;
      ce_q   <= '0;
      bd_q   <= 1'b0;
      epc_q  <= '0;
      bad_q  <= '0;
      css_q  <= '0;
      pss_q  <= '0;
    end else begin
      if (req_i) begin
        exl_q  <= exl_d;
        code_q <= code_d;
        ce_q   <= ce_d;
        bd_q   <= bd_d;
        epc_q  <= epc_d;
        bad_q  <= bad_d;
      end
      if (shadow_en) begin
        css_q <= css_d;
        pss_q <= pss_d;
      end
    end
  end

  assign exl_o  = exl_q;
  assign code_o = code_q;
  assign ce_o   = ce_q;
  assign bd_o   = bd_q;
  assign epc_o  = epc_q;
  assign bad_o  = bad_q;
  assign css_o  = css_q;
  assign pss_o  = pss_q;

  // R1: a delay-slot fault backs EPC up by one instruction and flags it
  assert_slot_epc_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_i && ((pc_i + STEP) != npc_i)) |=> (bd_q && (epc_q == $past(pc_i) - STEP)));

  // R2: the exception-level flag is always set after a request
  assert_exl_set_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    req_i |=> exl_q);

  // R6: shadow sets hold while exl or bev blocks the update
  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_i && (exl_q || bev_i)) |=> ($stable(css_q) && $stable(pss_q)));

  // R12: nothing changes without a request
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    !req_i |=> ($stable(epc_q) && $stable(bad_q) && $stable(code_q) && $stable(exl_q)));
endmodule

// File: rtl/exc_fetch_redirect.sv
module exc_fetch_redirect
  import exc_entry_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] handler_i,
  output logic          redirect_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] npc_o,
  output logic [AW-1:0] nnpc_o
);
  localparam logic [AW-1:0] STEP  = AW'(INSN_BYTES);
  localparam logic [AW-1:0] RST_V = AW'(BOOT_RESET);

  logic          redir_q, redir_d;
  logic [AW-1:0] pc_q, pc_d, npc_q, npc_d, nnpc_q, nnpc_d;

  always_comb begin
    redir_d = req_i;
    pc_d    = pc_q;
    npc_d   = npc_q;
    nnpc_d  = nnpc_q;
    if (req_i) begin
      pc_d   = handler_i;
      npc_d  = handler_i + STEP;
      nnpc_d = handler_i + (STEP << 1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      redir_q <= 1'b0;
      pc_q    <= RST_V;
      npc_q   <= RST_V + STEP;
      nnpc_q  <= RST_V + (STEP << 1);
    end else begin
      redir_q <= redir_d;
      if (req_i) begin
        pc_q   <= pc_d;
        npc_q  <= npc_d;
        nnpc_q <= nnpc_d;
      end
    end
  end

  assign redirect_o = redir_q;
  assign pc_o       = pc_q;
  assign npc_o      = npc_q;
  assign nnpc_o     = nnpc_q;

  // R7: the three fetch addresses stay one instruction apart
  assert_fetch_seq_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    redir_q |-> ((npc_q == pc_q + STEP) && (nnpc_q == npc_q + STEP)));

  // R7: redirect is a single-cycle strobe for a single request
  assert_redirect_pulse_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_i && !$past(req_i)) |=> ($rose(redir_q) && (pc_q == $past(handler_i))));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int AW = XLEN,
  parameter int CW = CODE_W,
  parameter int PW = CP_W,
  parameter int SW = SS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_valid,
  input  logic [CW-1:0] exc_code,
  input  logic          exc_refill,
  input  logic          exc_intr,
  input  logic [PW-1:0] cp_num,
  input  logic [AW-1:0] cur_pc,
  input  logic [AW-1:0] nxt_pc,
  input  logic [AW-1:0] bad_addr,
  input  logic [AW-1:0] ebase,
  input  logic          bev,
  input  logic          iv,
  input  logic [SW-1:0] ess,
  output logic          redirect,
  output logic [AW-1:0] fetch_pc,
  output logic [AW-1:0] fetch_npc,
  output logic [AW-1:0] fetch_nnpc,
  input  logic [2:0]    rd_sel,
  output logic [AW-1:0] rd_data
);
  localparam int BD_POS = CW + PW;

  logic [1:0]    rst_sync_q;
  logic          rst_ni;
  logic          exl;
  logic [CW-1:0] code;
  logic [PW-1:0] ce;
  logic          bd;
  logic [AW-1:0] epc, bad_q, handler;
  logic [SW-1:0] css, pss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  exc_vec_sel #(.AW(AW), .CW(CW)) u_vec (
    .refill_i (exc_refill),
    .intr_i   (exc_intr),
    .code_i   (exc_code),
    .exl_i    (exl),
    .bev_i    (bev),
    .iv_i     (iv),
    .base_i   (ebase),
    .handler_o(handler)
  );

  exc_state_regs #(.AW(AW), .CW(CW), .PW(PW), .SW(SW)) u_state (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .req_i   (exc_valid),
    .code_i  (exc_code),
    .refill_i(exc_refill),
    .cp_i    (cp_num),
    .pc_i    (cur_pc),
    .npc_i   (nxt_pc),
    .bad_i   (bad_addr),
    .bev_i   (bev),
    .ess_i   (ess),
    .exl_o   (exl),
    .code_o  (code),
    .ce_o    (ce),
    .bd_o    (bd),
    .epc_o   (epc),
    .bad_o   (bad_q),
    .css_o   (css),
    .pss_o   (pss)
  );

  exc_fetch_redirect #(.AW(AW)) u_fetch (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .req_i     (exc_valid),
    .handler_i (handler),
    .redirect_o(redirect),
    .pc_o      (fetch_pc),
    .npc_o     (fetch_npc),
    .nnpc_o    (fetch_nnpc)
  );

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_STATUS: rd_data[0] = exl;
      SEL_CAUSE: begin
        rd_data[CW-1:0]    = code;
        rd_data[CW +: PW]  = ce;
        rd_data[BD_POS]    = bd;
      end
      SEL_EPC:    rd_data = epc;
      SEL_BAD:    rd_data = bad_q;
      SEL_SHADOW: begin
        rd_data[SW-1:0]  = css;
        rd_data[SW +: SW] = pss;
      end
      default:    rd_data = '0;
    endcase
  end

  // R4: a refill with the flag clear lands on the base address itself
  assert_refill_base_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (exc_valid && exc_refill && !exl) |=> (fetch_pc == $past(ebase)));

  // R5: a vectored interrupt lands on base + 0x200
  assert_vint_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (exc_valid && exc_intr && !exc_refill && iv) |=> (fetch_pc == $past(ebase) + AW'(OFF_VINT)));

  // R10: coprocessor number reaches the cause register
  assert_cp_ce_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (exc_valid && (exc_code == CW'(C_CPU))) |=> (ce == $past(cp_num)));
endmodule

// File: tb/test_exc_entry_ctrl.sv
`timescale 1ns/1ps
module test_exc_entry_ctrl;
  localparam int CLK_PERIOD = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_valid;
  logic [4:0]  exc_code;
  logic        exc_refill, exc_intr;
  logic [1:0]  cp_num;
  logic [31:0] cur_pc, nxt_pc, bad_addr, ebase;
  logic        bev, iv;
  logic [3:0]  ess;
  logic        redirect;
  logic [31:0] fetch_pc, fetch_npc, fetch_nnpc;
  logic [2:0]  rd_sel;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  bit          m_exl, m_bd, m_redir;
  int unsigned m_code, m_ce, m_css, m_pss;
  logic [31:0] m_epc, m_bad, m_fpc;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_ctrl i_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
    .exc_refill(exc_refill), .exc_intr(exc_intr), .cp_num(cp_num),
    .cur_pc(cur_pc), .nxt_pc(nxt_pc), .bad_addr(bad_addr), .ebase(ebase),
    .bev(bev), .iv(iv), .ess(ess), .redirect(redirect), .fetch_pc(fetch_pc),
    .fetch_npc(fetch_npc), .fetch_nnpc(fetch_nnpc), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_exl = 0; m_bd = 0; m_redir = 0;
    m_code = 0; m_ce = 0; m_css = 0; m_pss = 0;
    m_epc = 0; m_bad = 0; m_fpc = 32'hBFC00000;
  endtask

  // full compare of ports and read port (R11 layout), called in the low clock phase
  task automatic compare(input string tag);
    logic [31:0] e;
    check(tag, "redirect", {31'b0, redirect}, {31'b0, m_redir});
    check(tag, "fetch_pc", fetch_pc, m_fpc);
    check(tag, "fetch_npc", fetch_npc, m_fpc + 4);
    check(tag, "fetch_nnpc", fetch_nnpc, m_fpc + 8);
    rd_sel = 3'd0; #1; check(tag, "status", rd_data, {31'b0, m_exl});
    e = 32'(m_code) | (32'(m_ce) << 5) | (32'(m_bd) << 7);
    rd_sel = 3'd1; #1; check(tag, "cause", rd_data, e);
    rd_sel = 3'd2; #1; check(tag, "epc", rd_data, m_epc);
    rd_sel = 3'd3; #1; check(tag, "badaddr", rd_data, m_bad);
    rd_sel = 3'd4; #1; check(tag, "shadow", rd_data, 32'(m_css) | (32'(m_pss) << 4));
    rd_sel = 3'd6; #1; check("R11", "unused select", rd_data, 32'h0);
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input bit v, input logic [4:0] code, input bit rf, input bit it,
                     input logic [1:0] cp, input logic [31:0] pc, input logic [31:0] npc,
                     input logic [31:0] bad, input bit b, input bit ivv, input logic [3:0] es,
                     input string tag);
    logic [31:0] h;
    exc_valid = v; exc_code = code; exc_refill = rf; exc_intr = it; cp_num = cp;
    cur_pc = pc; nxt_pc = npc; bad_addr = bad; bev = b; iv = ivv; ess = es;
    @(posedge clk);
    m_redir = v;
    if (v) begin
      if (rf)                         h = m_exl ? ebase + 32'h180 : ebase;
      else if (it)                    h = ivv ? ebase + 32'h200 : ebase + 32'h180;
      else if (code == 5'h0C && b)    h = 32'hBFC00200;
      else                            h = ebase + 32'h180;
      m_fpc = h;
      if (!m_exl && !b) begin m_pss = m_css; m_css = es; end
      if (pc + 4 != npc) begin m_epc = pc - 4; m_bd = 1; end
      else begin m_epc = pc; m_bd = 0; end
      m_code = code;
      m_ce = (code == 5'h0B) ? cp : 0;
      if (rf || (code >= 1 && code <= 5)) m_bad = bad;
      m_exl = 1;
    end
    @(negedge clk);
    exc_valid = 0;
    compare(tag);
  endtask

  task automatic idle(input string tag);
    cyc(0, 5'h1F, 1, 1, 2'd3, 32'h0, 32'h0, 32'h12345678, 0, 1, 4'hF, tag);
  endtask

  task automatic do_reset(input bit with_req);
    @(negedge clk);
    rst_n = 0;
    exc_valid = with_req; exc_code = 5'h02; exc_refill = 1; bad_addr = 32'hFFFF0000;
    cur_pc = 32'h100; nxt_pc = 32'h200; ess = 4'h7;
    @(negedge clk); @(negedge clk);
    model_reset();
    exc_valid = 0;
    compare("R8");
    rst_n = 1;
    repeat (3) @(negedge clk);
    compare("R8");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; exc_valid = 0; exc_code = 0; exc_refill = 0; exc_intr = 0; cp_num = 0;
    cur_pc = 0; nxt_pc = 0; bad_addr = 0; ebase = 32'h8000_0000; bev = 0; iv = 0;
    ess = 0; rd_sel = 0;
    model_reset();
    do_reset(0);

    // R2 R3 R6 R7: syscall, no delay slot, first entry updates shadow sets
    cyc(1, 5'h08, 0, 0, 2'd1, 32'h1000, 32'h1004, 32'hAAAA0000, 0, 0, 4'h3, "R3");
    idle("R12"); idle("R12");
    // R1: fault in a delay slot; R6 hold since exl already set
    cyc(1, 5'h0D, 0, 0, 2'd0, 32'h2000, 32'h3000, 32'h0, 0, 0, 4'h5, "R1");
    // R4 refill with exl=1 -> base+0x180; R9 latch bad address
    cyc(1, 5'h02, 1, 0, 2'd0, 32'h4000, 32'h4004, 32'hDEAD0000, 0, 0, 4'h1, "R4");
    // R5 vectored and non-vectored interrupt
    ebase = 32'h9000_1000;
    cyc(1, 5'h00, 0, 1, 2'd0, 32'h5000, 32'h5004, 32'h0, 0, 1, 4'h0, "R5");
    cyc(1, 5'h00, 0, 1, 2'd0, 32'h5000, 32'h5100, 32'h0, 0, 0, 4'h0, "R5");
    // R10 coprocessor number, then R2 CE cleared and R9 bad held
    cyc(1, 5'h0B, 0, 0, 2'd2, 32'h6000, 32'h6004, 32'h11110000, 0, 0, 4'h0, "R10");
    cyc(1, 5'h09, 0, 0, 2'd3, 32'h6004, 32'h6008, 32'h22220000, 0, 0, 4'h0, "R9");
    // R3 overflow with bev=1 goes to the boot vector, bev=0 to base+0x180
    cyc(1, 5'h0C, 0, 0, 2'd0, 32'h7000, 32'h7004, 32'h0, 1, 0, 4'h0, "R3");
    cyc(1, 5'h0C, 0, 0, 2'd0, 32'h7000, 32'h7004, 32'h0, 0, 0, 4'h0, "R3");
    // R7 back-to-back requests
    cyc(1, 5'h04, 0, 0, 2'd0, 32'h7100, 32'h7104, 32'h33330000, 0, 0, 4'h0, "R7");
    idle("R7");

    // R8: reset with a request pending at the same time
    do_reset(1);
    // R4 refill with exl=0 -> base itself; R6 update
    ebase = 32'hA000_0000;
    cyc(1, 5'h03, 1, 1, 2'd0, 32'h8000, 32'h8004, 32'h44440000, 0, 1, 4'h9, "R4");
    do_reset(0);
    // R6 bev=1 on first entry blocks shadow update; R9 address error latches
    cyc(1, 5'h05, 0, 0, 2'd0, 32'h9000, 32'h9004, 32'h55550000, 1, 0, 4'hA, "R6");
    cyc(1, 5'h01, 0, 0, 2'd0, 32'h9010, 32'h9000, 32'h66660000, 0, 0, 4'hB, "R9");
    idle("R12");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule